// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Sequencer

This block steers a Montgomery multiplier through one full modular exponentiation. The exponent is walked one bit at a time, least significant bit first. The multiplier has two interleaved slots, and the sequencer drives them as two logical streams. Slot 0 holds the squaring chain in register X. Slot 1 holds the accumulating product in register Y. Each command names two operand sources and a destination register. After each command the sequencer streams operand digit indices, lowest digit first. It then waits until every outstanding slot has returned its completion strobe.

A run has three phases. In mapping, the base and the constant one are carried into the Montgomery domain. In the exponent loop, the square of X and the conditional product Y*X for the same bit are issued in the same cycle on the two slots. In remapping, Y is multiplied by the constant 0…01, which removes the mapping factor. A one-cycle done pulse closes the run. The multiplier datapath and its operand storage sit outside this block.

Top module: `mexp_rl_seq`

## Requirements
- R1: After reset, busy_o, done_o, issue_o and dig_valid_o are 0 and phase_o is 0 (idle). A start_i sampled while idle raises busy_o in the next cycle, and the run steps through phase_o codes 1 (map), 2 (loop) and 3 (remap), in that order.
- R2: Mapping issues both slots in one cycle. Slot 0 (issue_o bit 0) gets a=BASE, b=R2, dst=X. Slot 1 (issue_o bit 1) gets a=ONE, b=R2, dst=Y. Source codes are BASE=0, R2=1, ONE=2, X=3, Y=4. Destination codes are NONE=0, X=1, Y=2.
- R3: In the cycle after every issue, dig_valid_o goes high for exactly OP_W cycles. During those cycles dig_idx_o counts 0, 1, …, OP_W-1.
- R4: The loop takes exponent bits from bit 0 upward, one issue cycle per bit. Slot 0 always gets X*X→X (a=3, b=3, dst=1). In the same cycle, slot 1 gets Y*X→Y (a=4, b=3, dst=2), but only when the bit is 1.
- R5: A new issue happens only after the digit feed has ended and every slot issued in the previous cycle has returned its mul_done_i strobe. A slot is never reissued while its command is still outstanding.
- R6: Remapping issues only slot 1, with Y*ONE→Y (a=4, b=2, dst=2).
- R7: The loop runs min(exp_len_i, EXP_W) iterations, using the length latched at start. With length 0 the run goes straight from mapping to remapping.
- R8: When the remap strobe arrives after the digit feed has ended, done_o is high for exactly one cycle, in the next cycle. busy_o falls in that same cycle.
- R9: A start_i pulse while busy_o is high has no effect on the running exponentiation.
- R10: If each command writes a*b mod N into its destination (BASE=m, R2=ONE=1), Y ends the run holding m^e mod N, where e is the exponent truncated to the loop length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| exp_i | input | EXP_W | Exponent, latched at start |
| exp_len_i | input | LEN_W | Exponent bit length, latched at start |
| mul_done_i | input | 2 | Per-slot completion strobe from the multiplier |
| issue_o | output | 2 | Per-slot command strobe |
| a_src_o | output | 2x3 | Per-slot first operand source |
| b_src_o | output | 2x3 | Per-slot second operand source |
| dst_o | output | 2x2 | Per-slot destination register |
| dig_valid_o | output | 1 | Digit feed active |
| dig_idx_o | output | IDX_W | Digit index being fed, lowest first |
| phase_o | output | 2 | Current phase: 0 idle, 1 map, 2 loop, 3 remap |
| busy_o | output | 1 | Exponentiation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with OP_W=4 and EXP_W=12. Each command then takes only a few cycles, and runs with all-ones exponents, zero exponents, a zero length and a length above EXP_W all fit in a short run. The bench sets the two slot latencies separately and also swaps them. This lets completion tracking meet strobes in either order, while the bench's modular-arithmetic responder turns any wrong operand choice or missing step into a wrong final value.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  localparam int unsigned NSLOT = 2;

  typedef enum logic [2:0] {
    SRC_BASE = 3'd0,
    SRC_R2   = 3'd1,
    SRC_ONE  = 3'd2,
    SRC_X    = 3'd3,
    SRC_Y    = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_X    = 2'd1,
    DST_Y    = 2'd2
  } dst_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_MAP   = 2'd1,
    PH_LOOP  = 2'd2,
    PH_REMAP = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FEED  = 2'd2,
    ST_WAIT  = 2'd3
  } st_e;

  typedef struct packed {
    src_e a;
    src_e b;
    dst_e d;
    logic en;
  } cmd_t;
endpackage

// File: rtl/mexp_feed.sv
module mexp_feed #(
  parameter int unsigned OP_W  = 64,
  parameter int unsigned IDX_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kick_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OP_W - 1);

  logic             run_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (kick_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == LAST_IDX) run_q <= 1'b0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = run_q;
  assign idx_o   = cnt_q;
  assign last_o  = run_q && (cnt_q == LAST_IDX);

  AST_FEED_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> idx_o == '0); // R3
  AST_FEED_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o); // R3
endmodule

// File: rtl/mexp_slot_track.sv
module mexp_slot_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic done_i,
  output logic open_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~done_i) | issue_i;
  end

  // still outstanding after this cycle's strobe
  assign open_o = pend_q & ~done_i;

  AST_NO_REISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !pend_q); // R5
endmodule

// File: rtl/mexp_cmd_dec.sv
module mexp_cmd_dec
  import mexp_pkg::*;
(
  input  phase_e               phase_i,
  input  logic                 exp_bit_i,
  output cmd_t   [NSLOT-1:0]   cmd_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == 0) begin : g_sq
      // squaring chain on X
      always_comb begin
        cmd_o[g] = '{a: SRC_BASE, b: SRC_BASE, d: DST_NONE, en: 1'b0};
        unique case (phase_i)
          PH_MAP:  cmd_o[g] = '{a: SRC_BASE, b: SRC_R2, d: DST_X, en: 1'b1};
          PH_LOOP: cmd_o[g] = '{a: SRC_X,    b: SRC_X,  d: DST_X, en: 1'b1};
          default: ;
        endcase
      end
    end else begin : g_acc
      // accumulator chain on Y
      always_comb begin
        cmd_o[g] = '{a: SRC_BASE, b: SRC_BASE, d: DST_NONE, en: 1'b0};
        unique case (phase_i)
          PH_MAP:   cmd_o[g] = '{a: SRC_ONE, b: SRC_R2,  d: DST_Y, en: 1'b1};
          PH_LOOP:  cmd_o[g] = '{a: SRC_Y,   b: SRC_X,   d: DST_Y, en: exp_bit_i};
          PH_REMAP: cmd_o[g] = '{a: SRC_Y,   b: SRC_ONE, d: DST_Y, en: 1'b1};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mexp_ctrl.sv
module mexp_ctrl
  import mexp_pkg::*;
#(
  parameter int unsigned EXP_W = 32,
  parameter int unsigned LEN_W = $clog2(EXP_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LEN_W-1:0] exp_len_i,
  input  logic             feed_last_i,
  input  logic             all_clear_i,
  output logic             issue_cyc_o,
  output phase_e           phase_o,
  output logic             exp_bit_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(EXP_W);

  st_e              st_q;
  phase_e           phase_q;
  logic [EXP_W-1:0] exp_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic             done_q;
  logic [EXP_W-1:0] exp_sh;
  logic [LEN_W-1:0] len_clamp;

  assign len_clamp = (exp_len_i > MAX_LEN) ? MAX_LEN : exp_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      phase_q <= PH_IDLE;
      exp_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          exp_q   <= exp_i;
          len_q   <= len_clamp;
          idx_q   <= '0;
          phase_q <= PH_MAP;
          st_q    <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_FEED;
        ST_FEED:  if (feed_last_i) st_q <= ST_WAIT;
        ST_WAIT:  if (all_clear_i) begin
          unique case (phase_q)
            PH_MAP: begin
              phase_q <= (len_q == '0) ? PH_REMAP : PH_LOOP;
              idx_q   <= '0;
              st_q    <= ST_ISSUE;
            end
            PH_LOOP: begin
              if (idx_q == len_q - 1'b1) phase_q <= PH_REMAP;
              else                       idx_q   <= idx_q + 1'b1;
              st_q <= ST_ISSUE;
            end
            default: begin
              phase_q <= PH_IDLE;
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign exp_sh      = exp_q >> idx_q;
  assign exp_bit_o   = exp_sh[0];
  assign issue_cyc_o = (st_q == ST_ISSUE);
  assign phase_o     = phase_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(exp_q) && $stable(len_q))); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_REMAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(phase_q) == PH_REMAP)); // R8
  AST_LOOP_AFTER_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOOP && $past(phase_q) != PH_LOOP) |-> $past(phase_q) == PH_MAP); // R1
  AST_REMAP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_REMAP && $past(phase_q) != PH_REMAP)
      |-> ($past(phase_q) == PH_LOOP || $past(phase_q) == PH_MAP)); // R1
endmodule

// File: rtl/mexp_rl_seq.sv
module mexp_rl_seq
  import mexp_pkg::*;
#(
  parameter int unsigned OP_W  = 64,
  parameter int unsigned EXP_W = 32,
  parameter int unsigned LEN_W = $clog2(EXP_W + 1),
  parameter int unsigned IDX_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [EXP_W-1:0]      exp_i,
  input  logic [LEN_W-1:0]      exp_len_i,
  input  logic [1:0]            mul_done_i,
  output logic [1:0]            issue_o,
  output logic [1:0][2:0]       a_src_o,
  output logic [1:0][2:0]       b_src_o,
  output logic [1:0][1:0]       dst_o,
  output logic                  dig_valid_o,
  output logic [IDX_W-1:0]      dig_idx_o,
  output logic [1:0]            phase_o,
  output logic                  busy_o,
  output logic                  done_o
);
  cmd_t   [NSLOT-1:0] cmd;
  logic   [NSLOT-1:0] open_w;
  logic               issue_cyc;
  logic               exp_bit;
  logic               feed_last;
  phase_e             phase;

  mexp_ctrl #(.EXP_W(EXP_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .exp_i       (exp_i),
    .exp_len_i   (exp_len_i),
    .feed_last_i (feed_last),
    .all_clear_i (~|open_w),
    .issue_cyc_o (issue_cyc),
    .phase_o     (phase),
    .exp_bit_o   (exp_bit),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  mexp_cmd_dec u_dec (
    .phase_i   (phase),
    .exp_bit_i (exp_bit),
    .cmd_o     (cmd)
  );

  mexp_feed #(.OP_W(OP_W), .IDX_W(IDX_W)) u_feed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (issue_cyc),
    .valid_o (dig_valid_o),
    .idx_o   (dig_idx_o),
    .last_o  (feed_last)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign issue_o[g] = issue_cyc & cmd[g].en;
    assign a_src_o[g] = cmd[g].a;
    assign b_src_o[g] = cmd[g].b;
    assign dst_o[g]   = cmd[g].d;

    mexp_slot_track u_trk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .issue_i (issue_o[g]),
      .done_i  (mul_done_i[g]),
      .open_o  (open_w[g])
    );
  end

  assign phase_o = phase;

  AST_MAP_BOTH_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o != 2'b00 && phase_o == 2'd1) |-> issue_o == 2'b11); // R2
  AST_SQUARE_EACH_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && phase_o == 2'd2 && !dig_valid_o && $past(phase_o) != 2'd2) |-> issue_o[0]); // R4
  AST_REMAP_SLOT1_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o != 2'b00 && phase_o == 2'd3) |-> issue_o == 2'b10); // R6
  AST_ISSUE_NOT_IN_FEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o != 2'b00) |-> !dig_valid_o); // R5
endmodule

// File: tb/mexp_rl_seq_tb_top.sv
module mexp_rl_seq_tb_top;
  localparam int OP_W  = 4;
  localparam int EXP_W = 12;
  localparam int LEN_W = $clog2(EXP_W + 1);
  localparam int IDX_W = $clog2(OP_W);
  localparam longint MODN = 65521;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [EXP_W-1:0] exp_i = '0;
  logic [LEN_W-1:0] exp_len_i = '0;
  logic [1:0] mul_done_i = '0;
  logic [1:0] issue_o;
  logic [1:0][2:0] a_src_o, b_src_o;
  logic [1:0][1:0] dst_o;
  logic dig_valid_o;
  logic [IDX_W-1:0] dig_idx_o;
  logic [1:0] phase_o;
  logic busy_o, done_o;

  always #4 clk = ~clk;

  mexp_rl_seq #(.OP_W(OP_W), .EXP_W(EXP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .exp_i(exp_i),
    .exp_len_i(exp_len_i), .mul_done_i(mul_done_i), .issue_o(issue_o),
    .a_src_o(a_src_o), .b_src_o(b_src_o), .dst_o(dst_o),
    .dig_valid_o(dig_valid_o), .dig_idx_o(dig_idx_o), .phase_o(phase_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit ref_busy = 0, ref_done = 0, saw_done = 0, start_req = 0;
  int feed_left = 0;
  int cnt [2] = '{-1, -1};
  int lat [2] = '{5, 8};
  longint cap_a [2], cap_b [2];
  int cap_d [2];
  bit cap_last [2];
  longint bx = 0, by = 0, base = 0;
  logic [EXP_W-1:0] stim_exp = '0;
  logic [LEN_W-1:0] stim_len = '0;
  int expq [$];

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int enc(int ph, int s, int a, int b, int d);
    return (ph << 16) | (s << 12) | (a << 8) | (b << 4) | d;
  endfunction

  function automatic longint srcval(int src);
    case (src)
      0: return base;
      3: return bx;
      4: return by;
      default: return 1;
    endcase
  endfunction

  function automatic longint powmod(longint m, logic [EXP_W-1:0] e, int len);
    longint r = 1, b = m % MODN;
    for (int i = 0; i < len; i++) begin
      if (e[i]) r = (r * b) % MODN;
      b = (b * b) % MODN;
    end
    return r;
  endfunction

  task automatic build_queue(logic [EXP_W-1:0] e, int len);
    int eff = (len > EXP_W) ? EXP_W : len;
    expq.delete();
    expq.push_back(enc(1, 0, 0, 1, 1));
    expq.push_back(enc(1, 1, 2, 1, 2));
    for (int i = 0; i < eff; i++) begin
      expq.push_back(enc(2, 0, 3, 3, 1));
      if (e[i]) expq.push_back(enc(2, 1, 4, 3, 2));
    end
    expq.push_back(enc(3, 1, 4, 2, 2));
  endtask

  task automatic step();
    bit busy_now, feed_active, remap_fire;
    logic [1:0] drv;
    @(negedge clk);
    cyc++;
    busy_now = ref_busy;
    check(busy_o == ref_busy, "R1 busy", busy_o, ref_busy);
    check(done_o == ref_done, "R8 done", done_o, ref_done);
    if (ref_done) saw_done = 1;
    feed_active = (feed_left > 0);
    check(dig_valid_o == feed_active, "R3 feed valid", dig_valid_o, feed_active);
    if (feed_active) begin
      check(dig_idx_o == OP_W - feed_left, "R3 feed index", dig_idx_o, OP_W - feed_left);
      feed_left--;
    end
    if (issue_o != 2'b00) begin
      check(!feed_active && cnt[0] < 0 && cnt[1] < 0, "R5 issue while outstanding",
            issue_o, 0);
    end
    drv = 2'b00;
    remap_fire = 0;
    for (int s = 0; s < 2; s++) begin
      if (cnt[s] > 0) begin
        cnt[s]--;
        if (cnt[s] == 0) begin
          longint p = (cap_a[s] * cap_b[s]) % MODN;
          drv[s] = 1'b1;
          cnt[s] = -1;
          if (cap_d[s] == 1) bx = p;
          else if (cap_d[s] == 2) by = p;
          if (cap_last[s]) remap_fire = 1;
        end
      end
    end
    for (int s = 0; s < 2; s++) begin
      if (issue_o[s]) begin
        int obs = enc(int'(phase_o), s, int'(a_src_o[s]), int'(b_src_o[s]), int'(dst_o[s]));
        if (expq.size() == 0) begin
          check(0, "R7 extra command", obs, -1);
        end else begin
          int want = expq.pop_front();
          string rq = (want >> 16 == 1) ? "R2 map command" :
                      (want >> 16 == 2) ? "R4 loop command" : "R6 remap command";
          check(obs == want, rq, obs, want);
        end
        cap_a[s] = srcval(int'(a_src_o[s]));
        cap_b[s] = srcval(int'(b_src_o[s]));
        cap_d[s] = int'(dst_o[s]);
        cap_last[s] = (expq.size() == 0);
        cnt[s] = lat[s];
      end
    end
    if (issue_o != 2'b00) feed_left = OP_W;
    ref_done = remap_fire;
    if (remap_fire) ref_busy = 0;
    start_i = start_req;
    exp_i = stim_exp;
    exp_len_i = stim_len;
    if (start_req && !busy_now) begin
      ref_busy = 1;
      build_queue(stim_exp, int'(stim_len));
    end
    start_req = 0;
    mul_done_i = drv;
    if (cyc > 150000) begin
      check(0, "watchdog global", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run(longint m, logic [EXP_W-1:0] e, int len, int l0, int l1,
                     int ignore_at, string tag);
    int eff = (len > EXP_W) ? EXP_W : len;
    int n = 0;
    base = m; bx = 0; by = 0;
    lat[0] = l0; lat[1] = l1;
    stim_exp = e; stim_len = LEN_W'(len);
    start_req = 1;
    saw_done = 0;
    while (!saw_done && n < 3000) begin
      if (n == ignore_at) begin
        start_req = 1;
        stim_exp = ~e;
        stim_len = LEN_W'(3);
      end
      step();
      n++;
    end
    check(saw_done, {tag, " watchdog run"}, n, 0);
    check(by == powmod(m, e, eff), {tag, " R10 result"}, by, powmod(m, e, eff));
    check(expq.size() == 0, {tag, " R7 command count"}, expq.size(), 0);
    step();
    check(!busy_o && !done_o, {tag, " R8 back to idle"}, {busy_o, done_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    check(busy_o == 0 && done_o == 0, "R1 reset busy/done", {busy_o, done_o}, 0);
    check(issue_o == 0 && dig_valid_o == 0, "R1 reset issue/feed", {issue_o, dig_valid_o}, 0);
    check(phase_o == 0, "R1 reset phase", phase_o, 0);
    run(1234, 12'b1011_0110_1101, 12, OP_W + 1, OP_W + 4, -1, "R4 mixed bits");
    run(777, 12'hFA3, 7, OP_W + 2, OP_W + 2, -1, "R7 short length");
    run(4321, 12'hABC, 0, OP_W + 1, OP_W + 3, -1, "R7 zero length");
    run(99, 12'hFFF, 15, OP_W + 3, OP_W + 1, -1, "R7 clamped length");
    run(31337, 12'h000, 6, OP_W + 1, OP_W + 1, -1, "R4 all zero bits");
    run(5555, 12'h9C1, 12, OP_W + 6, OP_W + 1, -1, "R5 swapped latency");
    run(2024, 12'h5A5, 10, OP_W + 2, OP_W + 5, 9, "R9 start while busy");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule